// File: doc/BRIEF.md
# Transmit Byte Queue with Byte and Word Push Registers

This block is the transmit-side queue of a serial flash controller. Software writes outgoing data through a 32-bit register port. A write to one of two push registers loads the queue: the byte push register loads a single byte, and the word push register loads four bytes. The serial shift engine drains the queue one byte at a time through a valid/take handshake. The queue is byte-granular, so single bytes and whole words can be mixed freely.

A transfer-status register reports the free space in bytes in its upper half. Software uses that figure to size each refill burst. The block raises an event when the queue drains to empty, when it fills completely, and when a push does not fit. These events, together with four events from the neighbouring receive and bus logic, are collected in an interrupt status register. Its bits are cleared by writing 1 to them. An enable register selects which status bits drive a level-high interrupt line.

Fill tracking is a three-state machine:
- States: `FILL_EMPTY`, `FILL_PART` and `FILL_FULL`.
- Transitions: *first-in* goes from EMPTY to PART; *top-off* goes from PART to FULL; *drain-start* goes from FULL to PART; *last-out* goes from PART to EMPTY.
- The direct EMPTY to FULL and FULL to EMPTY jumps are coded but cannot be reached with DEPTH of 8 or more.
- The full event fires on entry to FULL. The empty event fires on entry to EMPTY.

Top module: `txf_tx_fifo`

## Requirements
- R1: After reset the queue is empty, `tx_valid` is low, the status and enable registers read 0, the free-space field reads DEPTH, and `irq` is low.
- R2: A write to the byte push register (offset 0x0C) enqueues only `reg_wdata[7:0]`, as exactly one byte.
- R3: A write to the word push register (offset 0x10) enqueues four bytes in the order `[7:0]`, `[15:8]`, `[23:16]`, `[31:24]`.
- R4: The transfer-status register (offset 0x08) shows the free bytes (DEPTH minus occupancy) in bits 31:16. Bits 15:0 read 0.
- R5: A push larger than the free space, measured before any pop in the same cycle, enqueues only the bytes that fit and discards the rest. Occupancy never exceeds DEPTH. Such a push sets status bit 11 (overrun).
- R6: Status bit 10 (full) is set in the cycle in which occupancy becomes DEPTH.
- R7: Status bit 9 (empty) is set in the cycle in which the last byte leaves. It is not set while the queue simply stays empty.
- R8: Bytes leave in arrival order. `tx_valid` is high exactly when the queue holds data, and `tx_data` is the oldest byte. `tx_take` while the queue is empty has no effect.
- R9: A write to the status register (offset 0x00) clears each bit written as 1 and leaves bits written as 0. An event arriving in the same cycle as its clear leaves the bit set.
- R10: `ext_evt[0]`, `ext_evt[1]`, `ext_evt[2]` and `ext_evt[3]` set status bits 0 (receive underrun), 2 (receive ready), 3 (bus error) and 16 (transfer done).
- R11: The enable register (offset 0x04) stores only the seven implemented status bits. `irq` is high exactly while some status bit and its enable bit are both set.
- R12: Unimplemented status bits always read 0. Writes to the transfer-status register have no effect, and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte offset of the register access |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| tx_take | input | 1 | Shift engine consumes the head byte |
| tx_valid | output | 1 | Queue holds at least one byte |
| tx_data | output | 8 | Oldest byte in the queue |
| ext_evt | input | 4 | Event pulses from the receive and bus logic |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block at its defaults, DEPTH of 64 and ADDR_W of 5. At that size sixteen word pushes reach the full boundary. A later refill at 62 bytes puts a word push that only half fits within easy reach. Because DEPTH is a multiple of four, the bench also exercises a pop and a push on a full queue in the same cycle. The model checks that the pop does not make room for that push.

// File: rtl/txf_pkg.sv
package txf_pkg;

    // Bytes carried by one word push
    localparam int WORD_BYTES = 4;
    localparam int PUSH_CNT_W = $clog2(WORD_BYTES) + 1;

    // Status bit positions (decoded by neighbouring logic and software)
    localparam int STS_RX_UNDERRUN = 0;
    localparam int STS_RX_READY    = 2;
    localparam int STS_BUS_ERR     = 3;
    localparam int STS_TX_EMPTY    = 9;
    localparam int STS_TX_FULL     = 10;
    localparam int STS_TX_OVERRUN  = 11;
    localparam int STS_XFER_DONE   = 16;

    localparam logic [31:0] STS_IMPL_MASK = 32'h0001_0E0D;

    // Register byte offsets
    localparam int OFS_IRQ_STS   = 'h00;
    localparam int OFS_IRQ_EN    = 'h04;
    localparam int OFS_XFER_STAT = 'h08;
    localparam int OFS_PUSH_BYTE = 'h0C;
    localparam int OFS_PUSH_WORD = 'h10;

    // Fill-level states
    typedef enum logic [1:0] {
        FILL_EMPTY = 2'd0,
        FILL_PART  = 2'd1,
        FILL_FULL  = 2'd2
    } fill_state_e;

endpackage

// File: rtl/txf_push_decode.sv
module txf_push_decode
    import txf_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic                  wr_en_i,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic [31:0]           wdata_i,
    output logic [PUSH_CNT_W-1:0] push_cnt_o,
    output logic [31:0]           push_bytes_o,
    output logic [31:0]           sts_clr_o,
    output logic                  en_wr_o,
    output logic [31:0]           en_data_o
);

    logic hit_sts, hit_en, hit_pb, hit_pw;

    always_comb begin
        hit_sts = wr_en_i && (addr_i == ADDR_W'(OFS_IRQ_STS));
        hit_en  = wr_en_i && (addr_i == ADDR_W'(OFS_IRQ_EN));
        hit_pb  = wr_en_i && (addr_i == ADDR_W'(OFS_PUSH_BYTE));
        hit_pw  = wr_en_i && (addr_i == ADDR_W'(OFS_PUSH_WORD));
    end

    always_comb begin
        push_cnt_o   = '0;
        push_bytes_o = wdata_i;
        if (hit_pw) begin
            push_cnt_o = PUSH_CNT_W'(WORD_BYTES);
        end else if (hit_pb) begin
            push_cnt_o   = PUSH_CNT_W'(1);
            push_bytes_o = {24'h0, wdata_i[7:0]};
        end
        sts_clr_o = hit_sts ? wdata_i : 32'h0;
        en_wr_o   = hit_en;
        en_data_o = wdata_i;
    end

endmodule

// File: rtl/txf_byte_ring.sv
module txf_byte_ring
    import txf_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [PUSH_CNT_W-1:0] push_cnt_i,
    input  logic [31:0]           push_bytes_i,
    input  logic                  pop_req_i,
    output logic                  tx_valid_o,
    output logic [7:0]            tx_data_o,
    output logic [CNT_W-1:0]      free_o,
    output logic                  evt_empty_o,
    output logic                  evt_full_o,
    output logic                  evt_ovr_o
);

    logic [7:0]       mem [DEPTH];
    logic [7:0]       lane_byte [WORD_BYTES];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] cnt_q, cnt_d, space, acc, push_w;
    logic             pop;
    fill_state_e      state_q, state_d;

    // Split the word into its byte lanes
    for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
        assign lane_byte[g] = push_bytes_i[8*g +: 8];
    end

    always_comb begin
        space  = CNT_W'(DEPTH) - cnt_q;
        push_w = CNT_W'(push_cnt_i);
        acc    = (push_w > space) ? space : push_w;
        pop    = pop_req_i && (cnt_q != '0);
        cnt_d  = cnt_q + acc - CNT_W'(pop);
    end

    // Storage and pointers
    always_ff @(posedge clk) begin
        for (int i = 0; i < WORD_BYTES; i++) begin
            if (CNT_W'(i) < acc) begin
                mem[wr_ptr + PTR_W'(i)] <= lane_byte[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            wr_ptr <= wr_ptr + PTR_W'(acc);
            rd_ptr <= rd_ptr + PTR_W'(pop);
            cnt_q  <= cnt_d;
        end
    end

    // Fill-level state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FILL_EMPTY;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FILL_EMPTY: begin
                if (cnt_d == CNT_W'(DEPTH))   state_d = FILL_FULL;
                else if (cnt_d != '0)         state_d = FILL_PART;
            end
            FILL_PART: begin
                if (cnt_d == '0)              state_d = FILL_EMPTY;
                else if (cnt_d == CNT_W'(DEPTH)) state_d = FILL_FULL;
            end
            FILL_FULL: begin
                if (cnt_d == '0)              state_d = FILL_EMPTY;
                else if (cnt_d != CNT_W'(DEPTH)) state_d = FILL_PART;
            end
            default: state_d = FILL_EMPTY;
        endcase
    end

    // Outputs
    always_comb begin
        evt_empty_o = 1'b0;
        evt_full_o  = 1'b0;
        unique case (state_q)
            FILL_EMPTY: evt_full_o = (state_d == FILL_FULL);
            FILL_PART: begin
                evt_empty_o = (state_d == FILL_EMPTY);
                evt_full_o  = (state_d == FILL_FULL);
            end
            FILL_FULL: evt_empty_o = (state_d == FILL_EMPTY);
            default: ;
        endcase
        evt_ovr_o  = push_w > space;
        tx_valid_o = (state_q != FILL_EMPTY);
        tx_data_o  = mem[rd_ptr];
        free_o     = space;
    end

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(DEPTH));

    // R6
    full_reached_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_full_o |=> (cnt_q == CNT_W'(DEPTH)));

    // R7
    empty_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_empty_o |-> (cnt_q == CNT_W'(1)) && pop_req_i);

    // R8
    head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid_o && !pop_req_i) |=> $stable(tx_data_o));

endmodule

// File: rtl/txf_irq_ctrl.sv
module txf_irq_ctrl
    import txf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] set_i,
    input  logic [31:0] clr_i,
    input  logic        en_wr_i,
    input  logic [31:0] en_data_i,
    output logic [31:0] sts_o,
    output logic [31:0] en_o,
    output logic        irq_o
);

    logic [31:0] sts_q, en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sts_q <= '0;
            en_q  <= '0;
        end else begin
            sts_q <= ((sts_q & ~clr_i) | set_i) & STS_IMPL_MASK;
            if (en_wr_i) en_q <= en_data_i & STS_IMPL_MASK;
        end
    end

    always_comb begin
        sts_o = sts_q;
        en_o  = en_q;
        irq_o = |(sts_q & en_q);
    end

    // R9
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_i) |=> ((sts_q & $past(clr_i & ~set_i)) == 32'h0));

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((sts_q & $past(set_i & STS_IMPL_MASK))
                      == $past(set_i & STS_IMPL_MASK)));

    // R11
    irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(set_i & en_q)) && !en_wr_i) |=> irq_o);

endmodule

// File: rtl/txf_tx_fifo.sv
module txf_tx_fifo
    import txf_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int ADDR_W = 5,
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              tx_take,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    input  logic [3:0]        ext_evt,
    output logic              irq
);

    logic [PUSH_CNT_W-1:0] push_cnt;
    logic [31:0]           push_bytes, sts_clr, en_data, sts, en, set_vec;
    logic                  en_wr, evt_empty, evt_full, evt_ovr;
    logic [CNT_W-1:0]      free_bytes;

    txf_push_decode #(.ADDR_W(ADDR_W)) u_decode (
        .wr_en_i      (reg_wr_en),
        .addr_i       (reg_addr),
        .wdata_i      (reg_wdata),
        .push_cnt_o   (push_cnt),
        .push_bytes_o (push_bytes),
        .sts_clr_o    (sts_clr),
        .en_wr_o      (en_wr),
        .en_data_o    (en_data)
    );

    txf_byte_ring #(.DEPTH(DEPTH)) u_ring (
        .clk          (clk),
        .rst_n        (rst_n),
        .push_cnt_i   (push_cnt),
        .push_bytes_i (push_bytes),
        .pop_req_i    (tx_take),
        .tx_valid_o   (tx_valid),
        .tx_data_o    (tx_data),
        .free_o       (free_bytes),
        .evt_empty_o  (evt_empty),
        .evt_full_o   (evt_full),
        .evt_ovr_o    (evt_ovr)
    );

    always_comb begin
        set_vec                  = 32'h0;
        set_vec[STS_RX_UNDERRUN] = ext_evt[0];
        set_vec[STS_RX_READY]    = ext_evt[1];
        set_vec[STS_BUS_ERR]     = ext_evt[2];
        set_vec[STS_XFER_DONE]   = ext_evt[3];
        set_vec[STS_TX_EMPTY]    = evt_empty;
        set_vec[STS_TX_FULL]     = evt_full;
        set_vec[STS_TX_OVERRUN]  = evt_ovr;
    end

    txf_irq_ctrl u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (set_vec),
        .clr_i     (sts_clr),
        .en_wr_i   (en_wr),
        .en_data_i (en_data),
        .sts_o     (sts),
        .en_o      (en),
        .irq_o     (irq)
    );

    always_comb begin
        if (reg_addr == ADDR_W'(OFS_IRQ_STS))        reg_rdata = sts;
        else if (reg_addr == ADDR_W'(OFS_IRQ_EN))    reg_rdata = en;
        else if (reg_addr == ADDR_W'(OFS_XFER_STAT)) reg_rdata = {16'(free_bytes), 16'h0};
        else                                         reg_rdata = 32'h0;
    end

endmodule

// File: tb/txf_tx_fifo_bench.sv
module txf_tx_fifo_bench;

    localparam int DEPTH  = 64;
    localparam int ADDR_W = 5;
    localparam logic [31:0] MASK = 32'h0001_0E0D;
    localparam int A_STS = 'h00, A_EN = 'h04, A_STAT = 'h08, A_PB = 'h0C, A_PW = 'h10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr_en = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic              tx_take = 1'b0;
    logic              tx_valid;
    logic [7:0]        tx_data;
    logic [3:0]        ext_evt = '0;
    logic              irq;

    always #10 clk = ~clk;

    txf_tx_fifo #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_txf_tx_fifo (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_take(tx_take),
        .tx_valid(tx_valid), .tx_data(tx_data), .ext_evt(ext_evt), .irq(irq)
    );

    // Behavioural reference model
    logic [7:0]  q[$];
    logic [31:0] m_sts, m_en;
    int          checks = 0, failures = 0;
    bit          done = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete();
            m_sts = 0;
            m_en  = 0;
        end else begin
            int oc, n, sp, acc, nc;
            logic [31:0] setv;
            oc = q.size();
            n = 0;
            if (reg_wr_en && reg_addr == ADDR_W'(A_PB)) n = 1;
            if (reg_wr_en && reg_addr == ADDR_W'(A_PW)) n = 4;
            sp = DEPTH - oc;
            acc = (n < sp) ? n : sp;
            setv = 0;
            if (n > sp) setv[11] = 1'b1;
            if (tx_take && oc > 0) void'(q.pop_front());
            for (int k = 0; k < acc; k++) q.push_back(reg_wdata[8*k +: 8]);
            nc = q.size();
            if (oc != 0 && nc == 0) setv[9] = 1'b1;
            if (nc == DEPTH && oc != DEPTH) setv[10] = 1'b1;
            setv[0]  = ext_evt[0];
            setv[2]  = ext_evt[1];
            setv[3]  = ext_evt[2];
            setv[16] = ext_evt[3];
            if (reg_wr_en && reg_addr == ADDR_W'(A_STS)) m_sts = m_sts & ~reg_wdata;
            m_sts = (m_sts | setv) & MASK;
            if (reg_wr_en && reg_addr == ADDR_W'(A_EN)) m_en = reg_wdata & MASK;
        end
    end

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R8", "tx_valid", 32'(tx_valid), 32'(q.size() > 0));
            if (q.size() > 0) chk("R8", "tx_data", 32'(tx_data), 32'(q[0]));
            chk("R11", "irq", 32'(irq), 32'(|(m_sts & m_en)));
        end
    end

    task automatic cyc(input bit wr, input int a, input logic [31:0] d, input bit take, input logic [3:0] ev);
        @(negedge clk);
        reg_wr_en = wr; reg_addr = ADDR_W'(a); reg_wdata = d; tx_take = take; ext_evt = ev;
    endtask

    task automatic idle();
        cyc(0, 'h1C, 0, 0, 0);
    endtask

    task automatic rd_chk(input int a, input string tag);
        logic [31:0] exp;
        @(negedge clk);
        reg_wr_en = 0; tx_take = 0; ext_evt = 0; reg_addr = ADDR_W'(a);
        #1;
        if (a == A_STS)       exp = m_sts;
        else if (a == A_EN)   exp = m_en;
        else if (a == A_STAT) exp = (DEPTH - q.size()) << 16;
        else                  exp = 0;
        chk(tag, "register read", reg_rdata, exp);
    endtask

    task automatic drain(input int n);
        for (int k = 0; k < n; k++) cyc(0, 'h1C, 0, 1, 0);
        idle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd_chk(A_STS, "R1");
        rd_chk(A_EN, "R1");
        rd_chk(A_STAT, "R1");
        chk("R1", "irq after reset", 32'(irq), 0);
        // R11 enable keeps implemented bits only
        cyc(1, A_EN, 32'hFFFF_FFFF, 0, 0); idle();
        rd_chk(A_EN, "R11");
        // R2 byte push keeps low byte only
        cyc(1, A_PB, 32'hA5A5_A5C3, 0, 0); idle();
        rd_chk(A_STAT, "R2");
        // R3 word push, low byte first
        cyc(1, A_PW, 32'h4433_2211, 0, 0); idle();
        rd_chk(A_STAT, "R4");
        // R7 empty event on last byte out
        drain(5);
        rd_chk(A_STS, "R7");
        // R9 write-one-to-clear
        cyc(1, A_STS, 32'h0000_0200, 0, 0); idle();
        rd_chk(A_STS, "R9");
        cyc(0, 0, 0, 0, 4'b0010); idle();
        cyc(1, A_STS, 32'h0, 0, 0); idle();
        rd_chk(A_STS, "R9");
        cyc(1, A_STS, 32'hFFFF_FFFF, 0, 0); idle();
        // R8/R7 take while empty does nothing, no empty event
        drain(3);
        rd_chk(A_STS, "R7");
        rd_chk(A_STAT, "R8");
        // R6 fill to full with word pushes
        for (int k = 0; k < 16; k++) cyc(1, A_PW, 32'h0404_0404 * k + 32'h0302_0100, 0, 0);
        idle();
        rd_chk(A_STS, "R6");
        rd_chk(A_STAT, "R4");
        // R5 overrun on full
        cyc(1, A_PB, 32'h0000_00EE, 0, 0); idle();
        rd_chk(A_STS, "R5");
        cyc(1, A_STS, 32'hFFFF_FFFF, 0, 0); idle();
        // R5 pop does not free room for same-cycle push
        cyc(1, A_PW, 32'hDEAD_BEEF, 1, 0); idle();
        rd_chk(A_STS, "R5");
        rd_chk(A_STAT, "R5");
        // R5 partial accept at 62 bytes
        drain(1);
        cyc(1, A_STS, 32'hFFFF_FFFF, 0, 0);
        cyc(1, A_PW, 32'h9988_7766, 0, 0); idle();
        rd_chk(A_STS, "R5");
        rd_chk(A_STAT, "R5");
        // R12 status register write ignored, unmapped reads zero
        cyc(1, A_STAT, 32'h0000_0000, 0, 0); idle();
        rd_chk(A_STAT, "R12");
        rd_chk('h14, "R12");
        rd_chk(A_PW, "R12");
        // R10 external events, R9 set beats clear
        cyc(1, A_STS, 32'hFFFF_FFFF, 0, 0);
        cyc(0, 0, 0, 0, 4'b1111); idle();
        rd_chk(A_STS, "R10");
        cyc(1, A_STS, 32'h0000_0001, 0, 4'b0001); idle();
        rd_chk(A_STS, "R9");
        // R11 masking
        cyc(1, A_EN, 32'h0, 0, 0); idle();
        chk("R11", "irq masked", 32'(irq), 0);
        cyc(1, A_EN, 32'h0000_0004, 0, 0); idle();
        chk("R11", "irq enabled bit", 32'(irq), 1);
        // R8 drain all with FIFO order checked per clock
        drain(DEPTH);
        rd_chk(A_STS, "R7");
        rd_chk(A_STAT, "R4");
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            failures++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule